// File: doc/BRIEF.md
# Memory long-word negate unit

The unit negates, in place, a 32-bit two's-complement long word stored as two consecutive words of a 16-bit-wide synchronous data memory. A caller presents an even word address with a one-cycle start request. The unit reads the least significant word at that address and the most significant word at the next address. It forms zero minus the operand and writes both halves of the 32-bit result back to the same two locations. It then loads a six-bit condition flag register and pulses done.

The flags follow a DSP convention. Beside negative, zero, overflow and borrow, the unit reports an extension flag and an unnormalized flag, both taken from a 36-bit sign-extended view of the 32-bit result. An odd start address is refused. The unit pulses a misalignment error, writes nothing and leaves the flags as they were.

Top module: `lneg_unit`

## Requirements
- R1: While and directly after reset, busy_o, done_o, misalign_o and mem_we_o are low and flags_o is zero.
- R2: For an accepted even address A, the operand is {word at A+1, word at A}. The result 0 minus the operand is written back: its bits 15:0 go to A and its bits 31:16 go to A+1. No other location is written.
- R3: The memory accesses run in this order: read A, read A+1, write A, write A+1. Read data is expected one cycle after its address. done_o is high for exactly one cycle, starting at the fifth rising edge after the edge that accepted start_i. busy_o is high from the edge after acceptance through the done cycle.
- R4: flags_o is encoded as bit 5 E, bit 4 U, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. N equals bit 31 of the result. Z is set when the 32-bit result is zero.
- R5: V is set only when the operand is 0x80000000.
- R6: C is set for every nonzero operand and is clear for a zero operand.
- R7: E is set when bits 35 through 31 of the 36-bit sign-extended result are not all equal. For a 32-bit memory result it is therefore always clear.
- R8: U is set when bit 31 of the result equals bit 30.
- R9: A start with an odd address raises misalign_o for one cycle, starting at the accepting edge. It performs no memory write, leaves flags_o unchanged and does not assert busy_o.
- R10: start_i is ignored while busy_o is high.
- R11: flags_o changes only in the cycle in which done_o is high, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| addr_i | input | ADDR_W | Word address of the least significant word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse, flags valid |
| misalign_o | output | 1 | One-cycle odd-address error pulse |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after its address |
| flags_o | output | 6 | Condition flags {E,U,N,Z,V,C} |

## Verification
The bench drives start_i at a falling edge and counts falling edges after the accepting rising edge. busy_o must be high at the first of these falling edges. done_o and the new flags must appear at the fifth, and done_o must be low again at the sixth. The bench's memory model logs both writes as they occur, so the write order and addresses are checked against the expected four-cycle access sequence. misalign_o is sampled at the falling edge right after the accepting edge and must be low one cycle later. Memory and flags are then watched for eight further cycles to confirm that nothing changed.

// File: rtl/lneg_pkg.sv
package lneg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_CAPT, ST_WR_LO, ST_WR_HI, ST_DONE
  } state_e;

  typedef struct packed {
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/lneg_ctrl.sv
module lneg_ctrl
  import lneg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              misalign_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORDS-1:0]  cap_en_o,
  output logic              wsel_o,
  output logic              flag_ld_o
);
  state_e            state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic              misalign_q;
  logic              word_sel;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i && !addr_i[0]) state_d = ST_RD_LO;
      ST_RD_LO: state_d = ST_RD_HI;
      ST_RD_HI: state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_WR_LO;
      ST_WR_LO: state_d = ST_WR_HI;
      ST_WR_HI: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      misalign_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      misalign_q <= (state_q == ST_IDLE) && start_i && addr_i[0];
      if (state_q == ST_IDLE && start_i && !addr_i[0]) base_q <= addr_i;
    end
  end

  // odd word of the pair is selected in the second read and second write
  assign word_sel    = (state_q == ST_RD_HI) || (state_q == ST_WR_HI);
  assign mem_addr_o  = {base_q[ADDR_W-1:1], word_sel};
  assign mem_we_o    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign cap_en_o[0] = (state_q == ST_RD_HI);
  assign cap_en_o[1] = (state_q == ST_CAPT);
  assign wsel_o      = (state_q == ST_WR_HI);
  assign flag_ld_o   = (state_q == ST_WR_HI);
  assign done_o      = (state_q == ST_DONE);
  assign busy_o      = (state_q != ST_IDLE);
  assign misalign_o  = misalign_q;

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_we_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  p_misalign_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !busy_o && !mem_we_o);
  p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/lneg_alu.sv
module lneg_alu
  import lneg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4
) (
  input  logic [2*DATA_W-1:0] op_i,
  output logic [2*DATA_W-1:0] res_o,
  output flags_t              flags_o
);
  localparam int LW = 2 * DATA_W;
  localparam int XW = LW + EXT_W;

  logic [XW-1:0] ext;
  logic [EXT_W:0] guard;

  assign res_o = '0 - op_i;
  assign ext   = {{EXT_W{res_o[LW-1]}}, res_o};
  assign guard = ext[XW-1:LW-1];

  always_comb begin
    flags_o.n = res_o[LW-1];
    flags_o.z = (res_o == '0);
    flags_o.v = op_i[LW-1] && res_o[LW-1];   // only the most negative value
    flags_o.c = (op_i != '0);
    flags_o.e = !((&guard) || !(|guard));
    flags_o.u = (res_o[LW-1] == res_o[LW-2]);
  end
endmodule

// File: rtl/lneg_unit.sv
module lneg_unit
  import lneg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              misalign_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [5:0]        flags_o
);
  localparam int WORDS = 2;
  localparam int LW    = WORDS * DATA_W;

  logic [WORDS-1:0]  cap_en;
  logic              wsel, flag_ld;
  logic [DATA_W-1:0] op_q [WORDS];
  logic [LW-1:0]     op_w, res_w;
  flags_t            flags_d, flags_q;

  lneg_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .addr_i,
    .busy_o, .done_o, .misalign_o, .mem_addr_o, .mem_we_o,
    .cap_en_o(cap_en), .wsel_o(wsel), .flag_ld_o(flag_ld)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        op_q[g] <= '0;
      else if (cap_en[g]) op_q[g] <= mem_rdata_i;
    end
    assign op_w[g*DATA_W +: DATA_W] = op_q[g];
  end

  lneg_alu #(.DATA_W(DATA_W), .EXT_W(EXT_W)) i_alu (
    .op_i(op_w), .res_o(res_w), .flags_o(flags_d)
  );

  assign mem_wdata_o = wsel ? res_w[LW-1:DATA_W] : res_w[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (flag_ld) flags_q <= flags_d;
  end
  assign flags_o = flags_q;

  p_flags_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flags_o) |-> done_o);
  p_ovf_implies_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] |-> (flags_o[3] && flags_o[0]));
  p_zero_no_borrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[2] != flags_o[0]));
  p_first_wr_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !$past(mem_we_o)) |-> !mem_addr_o[0]);
endmodule

// File: tb/test_lneg_unit.sv
module test_lneg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic        busy, done, misalign, we;
  logic [15:0] maddr, wdata;
  logic [15:0] rdata = '0;
  logic [5:0]  flags;

  logic [15:0] mem [16];
  logic [15:0] wr_log [4];
  int          wr_cnt = 0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  lneg_unit i_lneg_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .misalign_o(misalign),
    .mem_addr_o(maddr), .mem_we_o(we), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .flags_o(flags)
  );

  always @(posedge clk) begin
    rdata <= mem[maddr[3:0]];
    if (we) begin
      mem[maddr[3:0]] <= wdata;
      if (wr_cnt < 4) wr_log[wr_cnt] <= maddr;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !misalign && !we, "R1 ctrl", {busy, done, misalign, we}, 0);
    chk(flags == 6'h00, "R1 flags", flags, 0);
  endtask

  task automatic t_negate(input int a, input logic [31:0] op, input logic [31:0] exp_res,
                          input logic [5:0] exp_fl, input string tag);
    int lat;
    @(negedge clk);
    mem[a] = op[15:0]; mem[a+1] = op[31:16];
    wr_cnt = 0;
    start = 1'b1; addr = 16'(a);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy, {"R3 busy ", tag}, busy, 1);
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, {"R3 done latency ", tag}, lat, 5);
    chk(flags == exp_fl, {"R4 R5 R6 R7 R8 flags ", tag}, flags, exp_fl);
    chk({mem[a+1], mem[a]} == exp_res, {"R2 result ", tag}, {mem[a+1], mem[a]}, exp_res);
    chk(wr_cnt == 2 && wr_log[0] == 16'(a) && wr_log[1] == 16'(a+1),
        {"R3 write order ", tag}, {wr_log[0], wr_log[1]}, {16'(a), 16'(a+1)});
    @(negedge clk);
    chk(!done && !busy, {"R3 done pulse ", tag}, {done, busy}, 0);
  endtask

  task automatic t_misalign();
    logic [5:0] fl0;
    @(negedge clk);
    mem[6] = 16'h1234; mem[7] = 16'h5678;
    fl0 = flags; wr_cnt = 0;
    start = 1'b1; addr = 16'd7;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(misalign && !busy, "R9 pulse", {misalign, busy}, 2'b10);
    @(negedge clk);
    chk(!misalign, "R9 pulse width", misalign, 0);
    repeat (8) @(negedge clk);
    chk(wr_cnt == 0, "R9 no write", wr_cnt, 0);
    chk(flags == fl0, "R9 R11 flags held", flags, fl0);
    chk(mem[6] == 16'h1234 && mem[7] == 16'h5678, "R9 memory", {mem[7], mem[6]}, 32'h56781234);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    mem[2] = 16'h0005; mem[3] = 16'h0000;
    mem[8] = 16'hBEEF; mem[9] = 16'hCAFE;
    wr_cnt = 0;
    start = 1'b1; addr = 16'd2;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; addr = 16'd8;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk(wr_cnt == 2, "R10 single operation", wr_cnt, 2);
    chk({mem[9], mem[8]} == 32'hCAFEBEEF, "R10 other location", {mem[9], mem[8]}, 32'hCAFEBEEF);
    chk({mem[3], mem[2]} == 32'hFFFFFFFB, "R10 R2 result", {mem[3], mem[2]}, 32'hFFFFFFFB);
    chk(!busy, "R10 idle", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_negate(0,  32'h00AAFF00, 32'hFF550100, 6'h19, "example");
    t_negate(4,  32'h00000000, 32'h00000000, 6'h14, "zero");
    t_negate(10, 32'h80000000, 32'h80000000, 6'h0B, "most negative");
    t_negate(12, 32'h00000001, 32'hFFFFFFFF, 6'h19, "one");
    t_negate(14, 32'hC0000000, 32'h40000000, 6'h01, "unnorm clear");
    t_negate(2,  32'hFFFFFFFF, 32'h00000001, 6'h11, "minus one");
    t_misalign();
    t_busy_ignore();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule